// File: doc/BRIEF.md
# Error Event Counter Bank with Overflow Policy

This block counts error events for a telecom line framer. Each event input is a one-cycle pulse, and each pulse adds one to that event's own counter. What a counter does when it reaches all ones depends on its interrupt enable. With the enable clear, the counter holds at its maximum and raises a saturation flag. With the enable set, the counter returns to zero, raises an overflow flag and drives the interrupt request.

A processor reads the bank one byte at a time, least significant byte first. Reading the low byte does three things in one cycle: it copies the whole counter into a snapshot register, clears the live counter, and clears that counter's two status flags. The upper bytes are then returned from the snapshot. A wide value is therefore read as one consistent value, and events that arrive during the read are kept in the live counter for the next read.

The snapshot has a two-state sequencer. `SNAP_IDLE` means no snapshot is held. `SNAP_HELD` means the snapshot belongs to one counter, the owner. The transition CAPTURE (IDLE to HELD) and the transition RECAPTURE (HELD to HELD with a new owner) both happen on any valid low-byte read. The transition RELEASE (HELD to IDLE) happens when the owner's most significant byte is read.

Top module: `pmc_event_bank`

## Requirements
- R1: Each counter adds one on every clock cycle in which its `ev_pulse` bit is high. All counters count independently, including in the same cycle.
- R2: Counter 0 is 24 bits wide and uses 3 bytes. Counters 1 to 3 are 16 bits wide and use 2 bytes. Byte b of counter i is at address 4*i+b, where byte 0 is the least significant byte. The status register is at address 16. Reading any other address, or a byte slot beyond a counter's width, returns 0x00 and changes no state.
- R3: A counter whose `irq_en` bit is 0 stays at all ones when another event arrives, and sets status bit i (the saturation flag).
- R4: A counter whose `irq_en` bit is 1 goes from all ones to zero on the next event, and sets status bit 4+i (the overflow flag).
- R5: `rd_data` carries the requested byte in the cycle after `rd_en` is sampled high. In every other cycle it is 0x00.
- R6: A low-byte read returns the counter's current low byte and clears the counter and its status bits i and 4+i. An event in the same cycle leaves the counter at 1.
- R7: The upper bytes return the snapshot taken at the last low-byte read of that counter. An upper byte of a counter that does not own the snapshot reads 0x00.
- R8: A status read returns the status byte and clears exactly the bits it returned. A bit that is set in the same cycle stays set.
- R9: `irq` is high exactly when at least one overflow flag is set and that counter's `irq_en` bit is 1.
- R10: After reset all counters and all flags are zero, `rd_data` is 0x00 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 4 | One-cycle event pulse, one bit per counter |
| irq_en | input | 4 | Per-counter interrupt enable (1 = wrap with interrupt, 0 = saturate) |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rd_addr | input | 8 | Byte address |
| rd_data | output | 8 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
Events and reads are both sampled on the rising clock edge. A counter therefore shows its new value one cycle after the pulse. Read data and the read's clearing effects become visible one cycle after the strobe. `irq` follows a status change in that same cycle, and it follows a change of `irq_en` with no delay.

The bench drives inputs on the falling edge and samples on the next falling edge. This puts every check half a period after the edge that produced the result. The checks where events and reads coincide drive both on the same falling edge, so they land on the same rising edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic {
        SNAP_IDLE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_e;

    function automatic int unsigned width_bytes(input int unsigned width);
        return (width + 7) / 8;
    endfunction

endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev,
    input  logic         clr,
    input  logic         wrap_en,
    output logic [W-1:0] cnt_o,
    output logic         sat_set,
    output logic         ovf_set
);

    logic [W-1:0] cnt_q;
    logic         at_max;

    assign at_max = &cnt_q;
    assign cnt_o  = cnt_q;

    always_comb begin
        sat_set = ev && !clr && at_max && !wrap_en;
        ovf_set = ev && !clr && at_max && wrap_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= W'(ev);
        end else if (ev && !(at_max && !wrap_en)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pmc_rd_ctrl.sv
module pmc_rd_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned N_CNT    = 4,
    parameter int unsigned AW       = 8,
    parameter int unsigned MAX_W    = 24,
    parameter int unsigned WIDE_IDX = 0,
    parameter int unsigned WIDE_W   = 24,
    parameter int unsigned NARROW_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [AW-1:0]                rd_addr,
    input  logic [N_CNT-1:0][MAX_W-1:0]  cnt_all,
    input  logic [7:0]                   stat_byte,
    output logic [7:0]                   rd_data,
    output logic [N_CNT-1:0]             clr_cnt,
    output logic                         stat_rd
);

    localparam int unsigned IW        = $clog2(N_CNT);
    localparam int unsigned STAT_ADDR = N_CNT * 4;
    localparam int unsigned WIDE_NB   = width_bytes(WIDE_W);
    localparam int unsigned NARROW_NB = width_bytes(NARROW_W);

    snap_state_e      state_q, state_d;
    logic [IW-1:0]    owner_q;
    logic [MAX_W-1:0] snap_q;
    logic [7:0]       data_d;

    logic             in_cnt_space;
    logic [IW-1:0]    idx;
    logic [1:0]       bsel;
    logic [2:0]       nbytes;
    logic             valid_byte, low_hit, top_hit, owner_hit;

    always_comb begin
        in_cnt_space = rd_en && (int'(rd_addr) < STAT_ADDR);
        idx          = rd_addr[IW+1:2];
        bsel         = rd_addr[1:0];
        nbytes       = (int'(idx) == WIDE_IDX) ? 3'(WIDE_NB) : 3'(NARROW_NB);
        valid_byte   = in_cnt_space && ({1'b0, bsel} < nbytes);
        low_hit      = valid_byte && (bsel == 2'd0);
        top_hit      = valid_byte && ({1'b0, bsel} == nbytes - 3'd1);
        owner_hit    = (state_q == SNAP_HELD) && (idx == owner_q);
        stat_rd      = rd_en && (int'(rd_addr) == STAT_ADDR);
        clr_cnt      = '0;
        if (low_hit) clr_cnt[idx] = 1'b1;
    end

    // next-state: CAPTURE, RECAPTURE, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_IDLE: if (low_hit) state_d = SNAP_HELD;
            SNAP_HELD: begin
                if (low_hit)                     state_d = SNAP_HELD;
                else if (top_hit && owner_hit)   state_d = SNAP_IDLE;
            end
            default: state_d = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SNAP_IDLE;
            owner_q <= '0;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (low_hit) begin
                owner_q <= idx;
                snap_q  <= cnt_all[idx];
            end
        end
    end

    // read data output
    always_comb begin
        data_d = 8'h00;
        if (stat_rd)                      data_d = stat_byte;
        else if (low_hit)                 data_d = cnt_all[idx][7:0];
        else if (valid_byte && owner_hit) data_d = snap_q[8*bsel +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= 8'h00;
        else        rd_data <= data_d;
    end

endmodule

// File: rtl/pmc_event_bank.sv
module pmc_event_bank #(
    parameter int unsigned N_CNT    = 4,
    parameter int unsigned AW       = 8,
    parameter int unsigned WIDE_IDX = 0,
    parameter int unsigned WIDE_W   = 24,
    parameter int unsigned NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CNT-1:0] ev_pulse,
    input  logic [N_CNT-1:0] irq_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data,
    output logic             irq
);

    localparam int unsigned MAX_W = (WIDE_W > NARROW_W) ? WIDE_W : NARROW_W;
    localparam int unsigned SW    = 2 * N_CNT;

    logic [N_CNT-1:0][MAX_W-1:0] cnt_all;
    logic [N_CNT-1:0]            sat_set, ovf_set, clr_cnt;
    logic                        stat_rd;
    logic [SW-1:0]               stat_q, stat_clr, stat_set;

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        localparam int unsigned W = (i == WIDE_IDX) ? WIDE_W : NARROW_W;
        logic [W-1:0] cnt_w;

        pmc_counter #(.W(W)) u_counter (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (ev_pulse[i]),
            .clr     (clr_cnt[i]),
            .wrap_en (irq_en[i]),
            .cnt_o   (cnt_w),
            .sat_set (sat_set[i]),
            .ovf_set (ovf_set[i])
        );

        assign cnt_all[i] = MAX_W'(cnt_w);
    end

    always_comb begin
        stat_set = {ovf_set, sat_set};
        stat_clr = {clr_cnt, clr_cnt};
        if (stat_rd) stat_clr = stat_clr | stat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | stat_set;
    end

    assign irq = |(stat_q[SW-1:N_CNT] & irq_en);

    pmc_rd_ctrl #(
        .N_CNT    (N_CNT),
        .AW       (AW),
        .MAX_W    (MAX_W),
        .WIDE_IDX (WIDE_IDX),
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) u_rd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .cnt_all   (cnt_all),
        .stat_byte (8'(stat_q)),
        .rd_data   (rd_data),
        .clr_cnt   (clr_cnt),
        .stat_rd   (stat_rd)
    );

endmodule

// File: rtl/pmc_event_bank_chk.sv
module pmc_event_bank_chk #(
    parameter int unsigned N_CNT    = 4,
    parameter int unsigned AW       = 8,
    parameter int unsigned MAX_W    = 24,
    parameter int unsigned NARROW_W = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_CNT-1:0]            ev_pulse,
    input logic [N_CNT-1:0]            irq_en,
    input logic                        rd_en,
    input logic [AW-1:0]               rd_addr,
    input logic [7:0]                  rd_data,
    input logic [N_CNT-1:0][MAX_W-1:0] cnt_all,
    input logic [N_CNT-1:0]            clr_cnt,
    input logic [2*N_CNT-1:0]          stat_q
);

    localparam int unsigned STAT_ADDR = N_CNT * 4;
    localparam logic [NARROW_W-1:0] NMAX = '1;

    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_all[1][NARROW_W-1:0] == NMAX && !irq_en[1] && !clr_cnt[1])
        |=> cnt_all[1][NARROW_W-1:0] == NMAX);

    // R3
    sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_all[1][NARROW_W-1:0] == NMAX && !irq_en[1] && !clr_cnt[1] && ev_pulse[1])
        |=> stat_q[1]);

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_all[1][NARROW_W-1:0] == NMAX && irq_en[1] && !clr_cnt[1] && ev_pulse[1])
        |=> (cnt_all[1] == '0) && stat_q[N_CNT+1]);

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cnt[1] && !ev_pulse[1]) |=> cnt_all[1] == '0);

    // R5
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == 8'h00);

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_addr) == STAT_ADDR && ev_pulse == '0) |=> stat_q == '0);

endmodule

bind pmc_event_bank pmc_event_bank_chk #(
    .N_CNT    (N_CNT),
    .AW       (AW),
    .MAX_W    (MAX_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_pulse (ev_pulse),
    .irq_en   (irq_en),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cnt_all  (cnt_all),
    .clr_cnt  (clr_cnt),
    .stat_q   (stat_q)
);

// File: tb/pmc_event_bank_bench.sv
`timescale 1ns/100ps
module pmc_event_bank_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ev_pulse = '0;
    logic [3:0] irq_en = 4'b1100;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pmc_event_bank u_pmc_event_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_pulse (ev_pulse),
        .irq_en   (irq_en),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    // {counter index, event count}
    localparam logic [17:0] VEC [0:6] = '{
        {2'd0, 16'd5}, {2'd1, 16'd0}, {2'd2, 16'd258}, {2'd3, 16'd1000},
        {2'd0, 16'd700}, {2'd1, 16'd255}, {2'd2, 16'd256}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) ev_pulse = m;
        end
        @(negedge clk) ev_pulse = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] ev, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; ev_pulse = ev;
        @(negedge clk);
        rd_en = 1'b0; ev_pulse = '0;
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] b0, b1, b2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rd_data", rd_data, 8'h00);
        chk("R10 irq", irq, 1'b0);
        rd(8'd16, 4'b0, d);  chk("R10 status", d, 8'h00);
        rd(8'd12, 4'b0, d);  chk("R10 counter3", d, 8'h00);
        chk("R5 idle data", rd_data, 8'h00);

        // R1/R2/R7 vector table
        for (int v = 0; v < 7; v++) begin
            logic [1:0]  ci;
            logic [15:0] n;
            ci = VEC[v][17:16];
            n  = VEC[v][15:0];
            pulse(4'b0001 << ci, int'(n));
            rd({4'd0, ci, 2'd0}, 4'b0, b0);
            rd({4'd0, ci, 2'd1}, 4'b0, b1);
            b2 = 8'h00;
            if (ci == 2'd0) rd(8'd2, 4'b0, b2);
            chk("R1 R2 R7 vector count", {b2, b1, b0}, {8'h00, n});
        end

        // R1 independence: all counters in the same cycles
        pulse(4'b1111, 10);
        for (int c = 0; c < 4; c++) begin
            rd(8'(c * 4), 4'b0, d);
            chk("R1 simultaneous", d, 8'd10);
        end

        // R7 coherent 24-bit snapshot, events during the read kept
        pulse(4'b0001, 300);
        rd(8'd0, 4'b0, b0);
        pulse(4'b0001, 5);
        rd(8'd1, 4'b0, b1);
        rd(8'd2, 4'b0, b2);
        chk("R7 snapshot", {b2, b1, b0}, 24'h00012C);
        rd(8'd1, 4'b0, d);   chk("R7 upper byte after release", d, 8'h00);
        rd(8'd0, 4'b0, d);   chk("R6 events during read kept", d, 8'd5);
        rd(8'd1, 4'b0, d);

        // R7 non-owner upper byte
        pulse(4'b0100, 515);
        rd(8'd8, 4'b0, d);   chk("R7 owner low", d, 8'h03);
        rd(8'd5, 4'b0, d);   chk("R7 non-owner upper", d, 8'h00);
        rd(8'd9, 4'b0, d);   chk("R7 owner upper", d, 8'h02);

        // R2 unused slots: zero, no side effect
        pulse(4'b0010, 7);
        rd(8'd6, 4'b0, d);   chk("R2 unused slot", d, 8'h00);
        rd(8'd20, 4'b0, d);  chk("R2 unused address", d, 8'h00);
        rd(8'd4, 4'b0, d);   chk("R2 counter untouched", d, 8'd7);
        rd(8'd5, 4'b0, d);

        // R6 event coincident with low-byte read
        pulse(4'b0010, 3);
        rd(8'd4, 4'b0010, d); chk("R6 low byte old value", d, 8'd3);
        rd(8'd5, 4'b0, d);
        rd(8'd4, 4'b0, d);    chk("R6 coincident event counted once", d, 8'd1);
        rd(8'd5, 4'b0, d);

        // R3 saturation on counter 1, counter 3 brought to all ones
        pulse(4'b1010, 65535);
        pulse(4'b0010, 2);
        chk("R9 no irq before overflow", irq, 1'b0);
        // R8 status read with coincident overflow of counter 3 (R4)
        rd(8'd16, 4'b1000, d);
        chk("R3 saturation flag", d, 8'h02);
        chk("R9 irq from overflow", irq, 1'b1);
        @(negedge clk) irq_en = 4'b0100;
        #1 chk("R9 irq masked", irq, 1'b0);
        @(negedge clk) irq_en = 4'b1100;
        #1 chk("R9 irq unmasked", irq, 1'b1);
        rd(8'd16, 4'b0, d);   chk("R8 bit set during read kept", d, 8'h80);
        chk("R8 irq after clear", irq, 1'b0);
        rd(8'd16, 4'b0, d);   chk("R8 status cleared", d, 8'h00);
        rd(8'd4, 4'b0, b0);
        rd(8'd5, 4'b0, b1);
        chk("R3 saturated value", {b1, b0}, 16'hFFFF);
        rd(8'd12, 4'b0, b0);
        rd(8'd13, 4'b0, b1);
        chk("R4 wrapped to zero", {b1, b0}, 16'h0000);

        // R6 low-byte read clears that counter's flags
        pulse(4'b0010, 65536);
        rd(8'd4, 4'b0, d);
        rd(8'd16, 4'b0, d);   chk("R6 flags cleared by counter read", d, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule